// File: doc/BRIEF.md
# Receive Character Buffer with Status Interrupts

This block sits between a serial receiver and a processor read port. It holds up to twelve received characters. Each entry is 12 bits: an 8-bit data byte and the 4 status bits the receiver produced with it. Characters leave in arrival order, one entry per pop.

The buffer drives four status flags: data ready, threshold reached, full and stale data. Each flag has its own interrupt enable, and a single interrupt line is the OR of the enabled flags. A counter of bit-time ticks measures how long the receive line has been quiet. When that quiet period passes 30 bit times while characters are still waiting, the stale-data flag marks the end of a block.

The write side uses a valid/ready handshake. A character is taken on any clock where `wr_valid` and `wr_ready` are both high. `wr_ready` falls only when the buffer is full, so `wr_ready` low is the full indication back to the receiver, and a character offered then is dropped. The read side is a pop request. A pop taken while `rd_avail` is high loads the oldest entry into `rd_word` at that clock edge. A pop while empty leaves `rd_word` and the buffer unchanged.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset the buffer is empty, `rd_avail` is 0, `wr_ready` is 1, `rd_word` is 0, `rx_flags` is 0 and `irq` is 0.
- R2: An accepted write stores `{wr_stat, wr_data}` as one entry; `rd_word[11:8]` carries the status bits and `rd_word[7:0]` the data byte.
- R3: Entries are returned in write order. A pop with `rd_avail` high places the oldest entry on `rd_word` at that clock edge and removes exactly one entry.
- R4: `rx_flags[0]` (data ready) and `rd_avail` are high exactly when at least one entry is stored.
- R5: `rx_flags[1]` (threshold) is high exactly when four or fewer free entries remain, that is at 8 or more stored entries.
- R6: `rx_flags[2]` (full) is high exactly when all 12 entries are used, and `wr_ready` is then low.
- R7: A write offered while full is dropped: the buffer still reads back the 12 earlier entries, unchanged and in order.
- R8: A pop while empty changes neither `rd_word` nor the buffer contents.
- R9: `rx_flags[3]` (stale data) rises once more than 30 `bit_tick` pulses have arrived with `line_busy` low and no write accepted, while at least one entry is stored. After 30 such ticks it is still low.
- R10: The stale-data flag and its tick count clear on `line_busy`, on any accepted write, and the flag drops when the buffer becomes empty.
- R11: `irq_pend[i]` equals `rx_flags[i] & irq_en[i]` for each of the four flags, and `irq` is the OR of `irq_pend`.
- R12: A write and a pop taken on the same clock leave the stored count unchanged and keep order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Receiver offers a character |
| wr_ready | output | 1 | Buffer can take a character (low = full) |
| wr_data | input | 8 | Received data byte |
| wr_stat | input | 4 | Status bits for the character |
| rd_pop | input | 1 | Pop request from the read port |
| rd_avail | output | 1 | At least one entry is stored |
| rd_word | output | 12 | Last popped entry {status, data} |
| line_busy | input | 1 | Receive line activity seen this cycle |
| bit_tick | input | 1 | One pulse per bit time |
| irq_en | input | 4 | Per-flag interrupt enables |
| rx_flags | output | 4 | {stale, full, threshold, ready} |
| irq_pend | output | 4 | Enabled flags |
| irq | output | 1 | OR of enabled flags |

## Verification
The bench goes after the exact edges of each flag. It checks that the threshold appears at the eighth entry and not the seventh, and that full appears only at the twelfth; a wrong comparison shows one of them a character early or late. It pushes into a full buffer and drains it. A design that overwrote on a full write would return a corrupted or shifted sequence. It counts idle ticks to 30 and 31, where an off-by-one timer raises stale data too soon. It also checks that line activity, a new character or emptying clears the stale flag. A pop on an empty buffer and a simultaneous push and pop are checked for corrupted pointers or a changed `rd_word`.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int DATA_W = 8;
  localparam int STAT_W = 4;
  localparam int WORD_W = DATA_W + STAT_W;
  localparam int NFLAG  = 4;

  // flag positions on rx_flags / irq_en / irq_pend
  localparam int F_READY = 0;
  localparam int F_HALF  = 1;
  localparam int F_FULL  = 2;
  localparam int F_STALE = 3;

  typedef struct packed {
    logic [STAT_W-1:0] stat;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 12,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  rx_entry_t        push_entry,
  input  logic             pop_req,
  output rx_entry_t        head_q,
  output logic [CNT_W-1:0] fill,
  output logic             is_full,
  output logic             is_empty,
  output logic             pop_done
);
  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;

  assign is_full  = (fill == CNT_W'(DEPTH));
  assign is_empty = (fill == '0);
  assign pop_done = pop_req && !is_empty;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic wr_go;
  assign wr_go = push && !is_full;

  always_ff @(posedge clk) begin
    if (wr_go) mem[wptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      fill   <= '0;
      head_q <= '0;
    end else begin
      if (wr_go) wptr <= ptr_next(wptr);
      if (pop_done) begin
        rptr   <= ptr_next(rptr);
        head_q <= mem[rptr];
      end
      case ({wr_go, pop_done})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && push && !pop_req) |=> is_full);
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && pop_req) |=> $stable(head_q));
  // R12
  both_ways_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && pop_done) |=> $stable(fill));
endmodule

// File: rtl/rxf_idle_timer.sv
module rxf_idle_timer #(
  parameter int IDLE_LIMIT = 30,
  localparam int TW = $clog2(IDLE_LIMIT + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_busy,
  input  logic char_in,
  input  logic bit_tick,
  output logic idle_over
);
  logic [TW-1:0] quiet;
  localparam logic [TW-1:0] SAT = TW'(IDLE_LIMIT + 1);

  always_ff @(posedge clk) begin
    if (!rst_n)                   quiet <= '0;
    else if (line_busy || char_in) quiet <= '0;
    else if (bit_tick && quiet != SAT) quiet <= quiet + 1'b1;
  end

  assign idle_over = (quiet > TW'(IDLE_LIMIT));

  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_busy || char_in) |=> !idle_over);
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags
  import rxf_pkg::*;
#(
  parameter int DEPTH     = 12,
  parameter int HALF_FREE = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill,
  input  logic             idle_over,
  input  flag_vec_t        en,
  output flag_vec_t        flags,
  output flag_vec_t        pend,
  output logic             any_irq
);
  localparam logic [CNT_W-1:0] HALF_AT = CNT_W'(DEPTH - HALF_FREE);

  always_comb begin
    flags          = '0;
    flags[F_READY] = (fill != '0);
    flags[F_HALF]  = (fill >= HALF_AT);
    flags[F_FULL]  = (fill == CNT_W'(DEPTH));
    flags[F_STALE] = (fill != '0) && idle_over;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_gate
    assign pend[i] = flags[i] & en[i];
  end

  assign any_irq = |pend;

  // R6
  full_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[F_FULL] |-> flags[F_HALF]);
  // R9
  stale_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[F_STALE] |-> flags[F_READY]);
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH      = 12,
  parameter int HALF_FREE  = 4,
  parameter int IDLE_LIMIT = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [7:0]  wr_data,
  input  logic [3:0]  wr_stat,
  input  logic        rd_pop,
  output logic        rd_avail,
  output logic [11:0] rd_word,
  input  logic        line_busy,
  input  logic        bit_tick,
  input  logic [3:0]  irq_en,
  output logic [3:0]  rx_flags,
  output logic [3:0]  irq_pend,
  output logic        irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] fill;
  logic             is_full, is_empty, pop_done, idle_over;
  rx_entry_t        head_q, in_entry;

  assign in_entry = '{stat: wr_stat, data: wr_data};
  assign wr_ready = !is_full;
  assign rd_avail = !is_empty;
  assign rd_word  = head_q;

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk, .rst_n,
    .push(wr_valid), .push_entry(in_entry), .pop_req(rd_pop),
    .head_q, .fill, .is_full, .is_empty, .pop_done
  );

  rxf_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
    .clk, .rst_n, .line_busy,
    .char_in(wr_valid && wr_ready), .bit_tick, .idle_over
  );

  rxf_flags #(.DEPTH(DEPTH), .HALF_FREE(HALF_FREE)) u_flags (
    .clk, .rst_n, .fill, .idle_over, .en(irq_en),
    .flags(rx_flags), .pend(irq_pend), .any_irq(irq)
  );

  // R3
  pop_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && rd_avail && !wr_valid && !is_full) |=> !is_full);
endmodule

// File: tb/rx_status_fifo_bench.sv
module rx_status_fifo_bench;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_pop = 0, line_busy = 0, bit_tick = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] wr_stat = 0, irq_en = 0;
  logic wr_ready, rd_avail, irq;
  logic [11:0] rd_word;
  logic [3:0] rx_flags, irq_pend;

  int checks = 0, errors = 0;
  logic [11:0] q[$];
  logic [11:0] last_word = 0;

  always #2.5 clk = ~clk;

  rx_status_fifo u_rx_status_fifo (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit p, bit pp, logic [11:0] w, bit t, bit b);
    @(negedge clk);
    wr_valid = p; wr_stat = w[11:8]; wr_data = w[7:0];
    rd_pop = pp; bit_tick = t; line_busy = b;
    @(posedge clk);
    if (pp && q.size() > 0) last_word = q.pop_front();
    if (p && q.size() < 12 + (pp ? 1 : 0) && !(q.size() == 12)) q.push_back(w);
    #1;
    wr_valid = 0; rd_pop = 0; bit_tick = 0; line_busy = 0;
  endtask

  task automatic push(logic [11:0] w); cyc(1, 0, w, 0, 0); endtask
  task automatic pop(); cyc(0, 1, 12'h0, 0, 0); endtask
  task automatic tick(); cyc(0, 0, 12'h0, 1, 0); endtask

  task automatic drain_check(string req);
    while (rd_avail) begin
      pop();
      chk(req, rd_word, last_word);
    end
    chk(req, q.size(), 0);
  endtask

  task automatic t_reset();
    chk("R1 rd_avail", rd_avail, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 rd_word", rd_word, 0);
    chk("R1 flags", rx_flags, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < 12; i++) begin
      push({4'(i), 8'hA0 + 8'(i)});
      chk("R4 ready", rx_flags[0], 1);
      chk("R4 rd_avail", rd_avail, 1);
      chk("R5 threshold", rx_flags[1], (i + 1 >= 8) ? 1 : 0);
      chk("R6 full", rx_flags[2], (i + 1 == 12) ? 1 : 0);
    end
    chk("R6 wr_ready", wr_ready, 0);
    push(12'hFEE);
    push(12'hDDD);
    chk("R7 still full", rx_flags[2], 1);
    chk("R7 model size", q.size(), 12);
    pop();
    chk("R2 first word", rd_word, 12'h0A0);
    chk("R6 full cleared", rx_flags[2], 0);
    drain_check("R3 order");
    chk("R4 empty ready", rx_flags[0], 0);
  endtask

  task automatic t_empty_pop();
    logic [11:0] held;
    push(12'h5C3);
    pop();
    chk("R2 status/data", rd_word, 12'h5C3);
    held = rd_word;
    pop();
    pop();
    chk("R8 word held", rd_word, held);
    chk("R8 still empty", rd_avail, 0);
    push(12'h1B4);
    pop();
    chk("R8 pointers intact", rd_word, 12'h1B4);
  endtask

  task automatic t_stale();
    push(12'h777);
    for (int i = 0; i < 30; i++) tick();
    chk("R9 30 ticks", rx_flags[3], 0);
    tick();
    chk("R9 31 ticks", rx_flags[3], 1);
    cyc(0, 0, 12'h0, 0, 1);
    chk("R10 line busy", rx_flags[3], 0);
    for (int i = 0; i < 31; i++) tick();
    chk("R9 again", rx_flags[3], 1);
    push(12'h778);
    chk("R10 new char", rx_flags[3], 0);
    for (int i = 0; i < 31; i++) tick();
    chk("R9 third", rx_flags[3], 1);
    pop();
    chk("R10 one left", rx_flags[3], 1);
    pop();
    chk("R10 empty", rx_flags[3], 0);
    for (int i = 0; i < 40; i++) tick();
    chk("R10 empty no stale", rx_flags[3], 0);
  endtask

  task automatic t_irq();
    for (int i = 0; i < 8; i++) push(12'h300 + 12'(i));
    irq_en = 4'b0000; #1;
    chk("R11 none", {irq, irq_pend}, 5'b0);
    irq_en = 4'b0010; #1;
    chk("R11 half", {irq, irq_pend}, 5'b10010);
    irq_en = 4'b0100; #1;
    chk("R11 full off", {irq, irq_pend}, 5'b0);
    irq_en = 4'b1111; #1;
    chk("R11 all", {irq, irq_pend}, 5'b10011);
    drain_check("R11 drain");
    irq_en = 4'b0000;
  endtask

  task automatic t_simul();
    push(12'h901); push(12'h902); push(12'h903);
    cyc(1, 1, 12'h904, 0, 0);
    chk("R12 pop word", rd_word, 12'h901);
    chk("R12 threshold stays", rx_flags[1], 0);
    chk("R12 model size", q.size(), 3);
    for (int i = 0; i < 9; i++) push(12'h910 + 12'(i));
    chk("R12 full at 12", rx_flags[2], 1);
    drain_check("R12 order");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    t_reset();
    t_fill_drain();
    t_empty_pop();
    t_stale();
    t_irq();
    t_simul();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule